// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, before any page-table walk starts, whether a logical address falls inside one of a small set of programmable transparent windows. Each window is one 32-bit configuration word. The word holds an upper-byte base, a per-bit ignore mask over that byte, an enable bit, a privilege selector and a write-protect bit. There are two windows for instruction fetches and two for data accesses. The fetch flag of the request decides which pair is consulted.

When a window matches, the physical address is the logical address unchanged. The block grants read and execute, and grants write only when the window is not write-protected. A store that hits a write-protected window is flagged as a protection fault. A probe request also returns a status word that marks the access as a transparent, resident hit. All results are registered once, so a request presented in one cycle is answered in the next. The configuration words are loaded through a one-cycle write port.

Top module: `ttw_match`

## Requirements
- R1: After reset every window is disabled, so every request misses and all response outputs are zero.
- R2: A window whose enable bit (bit 15) is 0 never matches, whatever its other fields hold.
- R3: The privilege field (bits 14:13) works as follows. 2'b00 matches only user accesses (req_super=0). 2'b01 matches only supervisor accesses. 2'b10 and 2'b11 match both.
- R4: Address bit 24+k is compared with base bit 24+k only when mask bit 16+k is 0. A mask bit of 1 makes that address bit ignored. Address bits 23:0 never take part.
- R5: A hit sets rsp_rd and rsp_ex. It sets rsp_wr only when the winning window's write-protect bit (bit 2) is 0. A miss grants no permission.
- R6: When req_fetch is 1, only the instruction windows are consulted. When req_fetch is 0, only the data windows are consulted.
- R7: When several consulted windows match, the lowest-numbered one wins. rsp_win reports its index, and its write-protect bit sets the permissions.
- R8: On a hit, rsp_phys equals the request address. On a miss it is 0.
- R9: A probe request (req_probe=1) that hits returns rsp_probe_stat = 32'h3, where bit 1 means transparent and bit 0 means resident. A probe miss and any non-probe request return 0.
- R10: rsp_wp_fault is 1 exactly when a store (req_store=1) hits a write-protected window.
- R11: When cfg_we is 1, cfg_wdata is loaded in one cycle into the window chosen by cfg_instr (1 = instruction, 0 = data) and cfg_idx. The new word applies from the next request onward, so a request in the same cycle sees the old word. An index at or above the number of windows is ignored.
- R12: Results appear one cycle after the request. rsp_valid copies req_valid one cycle later, and a cycle with req_valid=0 yields all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_instr | input | 1 | Write targets the instruction (1) or data (0) windows |
| cfg_idx | input | CFG_IDX_W (2) | Window index for the write |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Request present |
| req_addr | input | AW (32) | Logical address |
| req_super | input | 1 | Supervisor access |
| req_fetch | input | 1 | Instruction fetch |
| req_store | input | 1 | Store access |
| req_probe | input | 1 | Probe (test) access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | SEL_W (1) | Index of the winning window |
| rsp_phys | output | AW (32) | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |
| rsp_wp_fault | output | 1 | Store hit a write-protected window |
| rsp_probe_stat | output | 32 | Probe status word |

## Verification
On every cycle, the assertions check how the registered outputs relate to each other and to the previous request. Write permission always comes with read and execute permission, and a miss grants nothing. A hit returns the previous address as the physical address, and a probe hit returns the fixed status word. A fault only arises from a store that lacked write permission, and the valid flag follows the request by one cycle. Which window wins, how the privilege selector and the ignore mask behave, how the fetch flag picks a pair, and how writes to the configuration take effect all depend on stored contents. Only the bench's reference model can show those, across its scenarios.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int CFG_W    = 32;
  localparam int FIELD_W  = 8;
  localparam int BASE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 15;
  localparam int PRIV_LSB = 13;
  localparam int WP_BIT   = 2;

  typedef enum logic [1:0] {
    PRIV_USER_ONLY  = 2'b00,
    PRIV_SUPER_ONLY = 2'b01,
    PRIV_EITHER     = 2'b10,
    PRIV_EITHER_ALT = 2'b11
  } priv_sel_e;

  localparam logic [31:0] STAT_RESIDENT    = 32'h0000_0001;
  localparam logic [31:0] STAT_TRANSPARENT = 32'h0000_0002;
  localparam logic [31:0] PROBE_HIT_STAT   = STAT_RESIDENT | STAT_TRANSPARENT;
endpackage

// File: rtl/ttw_regbank.sv
module ttw_regbank
  import ttw_pkg::*;
#(
  parameter int WIN   = 2,
  parameter int IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic                       instr,
  input  logic [IDX_W-1:0]           idx,
  input  logic [CFG_W-1:0]           wdata,
  output logic [WIN-1:0][CFG_W-1:0]  icfg,
  output logic [WIN-1:0][CFG_W-1:0]  dcfg
);
  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar w = 0; w < WIN; w++) begin : g_win
      logic             ld;
      logic [CFG_W-1:0] cfg_q;
      logic [CFG_W-1:0] cfg_d;

      assign ld = we && (instr == 1'(s)) && (idx == IDX_W'(w));

      always_comb begin
        cfg_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q <= '0;
        end else if (ld) begin
          cfg_q <= cfg_d;
        end
      end

      if (s == 1) begin : g_i
        assign icfg[w] = cfg_q;
      end else begin : g_d
        assign dcfg[w] = cfg_q;
      end
    end
  end
endmodule

// File: rtl/ttw_window_cmp.sv
module ttw_window_cmp
  import ttw_pkg::*;
(
  input  logic [CFG_W-1:0]   cfg,
  input  logic [FIELD_W-1:0] addr_hi,
  input  logic               is_sup,
  output logic               match,
  output logic               wprot
);
  logic [FIELD_W-1:0] base;
  logic [FIELD_W-1:0] ign;
  logic [FIELD_W-1:0] diff;
  logic               priv_ok;
  priv_sel_e          priv;
  logic               unused_cfg;

  assign base = cfg[BASE_LSB +: FIELD_W];
  assign ign  = cfg[MASK_LSB +: FIELD_W];
  assign priv = priv_sel_e'(cfg[PRIV_LSB +: 2]);
  assign diff = (addr_hi ^ base) & ~ign;
  assign unused_cfg = ^cfg;

  always_comb begin
    case (priv)
      PRIV_USER_ONLY:  priv_ok = !is_sup;
      PRIV_SUPER_ONLY: priv_ok = is_sup;
      default:         priv_ok = 1'b1;
    endcase
  end

  assign match = cfg[EN_BIT] && priv_ok && (diff == '0);
  assign wprot = cfg[WP_BIT];
endmodule

// File: rtl/ttw_select.sv
module ttw_select #(
  parameter int WIN   = 2,
  parameter int SEL_W = 1
) (
  input  logic [WIN-1:0]   match,
  input  logic [WIN-1:0]   wprot,
  output logic             any,
  output logic [SEL_W-1:0] idx,
  output logic             win_wp
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    win_wp = 1'b0;
    for (int w = WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        any    = 1'b1;
        idx    = SEL_W'(w);
        win_wp = wprot[w];
      end
    end
  end
endmodule

// File: rtl/ttw_match.sv
module ttw_match
  import ttw_pkg::*;
#(
  parameter int WIN       = 2,
  parameter int CFG_IDX_W = 2,
  parameter int AW        = 32,
  localparam int SEL_W    = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_instr,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_super,
  input  logic                 req_fetch,
  input  logic                 req_store,
  input  logic                 req_probe,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [SEL_W-1:0]     rsp_win,
  output logic [AW-1:0]        rsp_phys,
  output logic                 rsp_rd,
  output logic                 rsp_wr,
  output logic                 rsp_ex,
  output logic                 rsp_wp_fault,
  output logic [31:0]          rsp_probe_stat
);
  // reset: asynchronous assertion, two-stage synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration storage
  logic [WIN-1:0][CFG_W-1:0] icfg;
  logic [WIN-1:0][CFG_W-1:0] dcfg;

  ttw_regbank #(.WIN(WIN), .IDX_W(CFG_IDX_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .instr (cfg_instr),
    .idx   (cfg_idx),
    .wdata (cfg_wdata),
    .icfg  (icfg),
    .dcfg  (dcfg)
  );

  // per-window comparison on the pair picked by the fetch flag
  logic [WIN-1:0] win_match;
  logic [WIN-1:0] win_wp;

  for (genvar w = 0; w < WIN; w++) begin : g_cmp
    logic [CFG_W-1:0] cfg_sel;
    assign cfg_sel = req_fetch ? icfg[w] : dcfg[w];

    ttw_window_cmp u_cmp (
      .cfg     (cfg_sel),
      .addr_hi (req_addr[AW-1 -: FIELD_W]),
      .is_sup  (req_super),
      .match   (win_match[w]),
      .wprot   (win_wp[w])
    );
  end

  logic             any_hit;
  logic [SEL_W-1:0] hit_idx;
  logic             hit_wp;

  ttw_select #(.WIN(WIN), .SEL_W(SEL_W)) u_sel (
    .match  (win_match),
    .wprot  (win_wp),
    .any    (any_hit),
    .idx    (hit_idx),
    .win_wp (hit_wp)
  );

  // next-state of the response stage
  logic             hit_d;
  logic             valid_d;
  logic [SEL_W-1:0] win_d;
  logic [AW-1:0]    phys_d;
  logic             rd_d, wr_d, ex_d, fault_d;
  logic [31:0]      stat_d;
  logic             rsp_en;

  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && any_hit;
    win_d   = hit_d ? hit_idx : '0;
    phys_d  = hit_d ? req_addr : '0;
    rd_d    = hit_d;
    ex_d    = hit_d;
    wr_d    = hit_d && !hit_wp;
    fault_d = hit_d && hit_wp && req_store;
    stat_d  = (hit_d && req_probe) ? PROBE_HIT_STAT : 32'h0;
  end

  assign rsp_en = req_valid || rsp_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_win        <= '0;
      rsp_phys       <= '0;
      rsp_rd         <= 1'b0;
      rsp_wr         <= 1'b0;
      rsp_ex         <= 1'b0;
      rsp_wp_fault   <= 1'b0;
      rsp_probe_stat <= '0;
    end else if (rsp_en) begin
      rsp_valid      <= valid_d;
      rsp_hit        <= hit_d;
      rsp_win        <= win_d;
      rsp_phys       <= phys_d;
      rsp_rd         <= rd_d;
      rsp_wr         <= wr_d;
      rsp_ex         <= ex_d;
      rsp_wp_fault   <= fault_d;
      rsp_probe_stat <= stat_d;
    end
  end

  // properties over the response stage
  a_r5_write_needs_rd_ex: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_wr |-> (rsp_rd && rsp_ex));

  a_r5_miss_grants_none: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rsp_hit |-> !(rsp_rd || rsp_wr || rsp_ex));

  a_r8_phys_is_logical: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_hit |-> (rsp_phys == $past(req_addr)));

  a_r9_probe_hit_status: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_hit && $past(req_probe)) |-> (rsp_probe_stat == PROBE_HIT_STAT));

  a_r10_fault_from_store: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_wp_fault |-> (rsp_hit && !rsp_wr && $past(req_store)));

  a_r12_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid == $past(req_valid));
endmodule

// File: tb/test_ttw_match.sv
module test_ttw_match;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_instr;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_super, req_fetch, req_store, req_probe;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault;
  logic [0:0]  rsp_win;
  logic [31:0] rsp_phys, rsp_probe_stat;

  always #5 clk = ~clk;

  ttw_match i_ttw_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_instr(cfg_instr),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_super(req_super), .req_fetch(req_fetch),
    .req_store(req_store), .req_probe(req_probe), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_phys(rsp_phys),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .rsp_wp_fault(rsp_wp_fault), .rsp_probe_stat(rsp_probe_stat)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_tag  = "R1";
  bit    done     = 0;

  logic [31:0] m_i [2];
  logic [31:0] m_d [2];
  logic [70:0] expv;
  logic [70:0] actv;

  function automatic logic [31:0] mk(logic [7:0] base, logic [7:0] ign,
                                     bit en, logic [1:0] priv, bit wp);
    return {base, ign, en, priv, 10'b0, wp, 2'b0};
  endfunction

  // reference model: evaluated at each edge on old contents, then updated
  always @(posedge clk) begin
    logic [31:0] r;
    int          hw;
    bit          pok;
    bit          hit;
    bit          wp;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_i[k] = '0; m_d[k] = '0; end
      expv = '0;
    end else begin
      hw = -1; wp = 0;
      for (int w = 0; w < 2; w++) begin
        r = req_fetch ? m_i[w] : m_d[w];
        if (r[14:13] == 2'b00)      pok = !req_super;
        else if (r[14:13] == 2'b01) pok = req_super;
        else                        pok = 1;
        if (hw < 0 && r[15] && pok &&
            (((req_addr[31:24] ^ r[31:24]) & ~r[23:16]) == 8'h0)) begin
          hw = w; wp = r[2];
        end
      end
      hit = req_valid && (hw >= 0);
      expv = {req_valid, hit, (hit ? 1'(hw) : 1'b0), hit, hit && !wp, hit,
              hit && wp && req_store, (hit ? req_addr : 32'h0),
              ((hit && req_probe) ? 32'h3 : 32'h0)};
      if (cfg_we && cfg_idx < 2) begin
        if (cfg_instr) m_i[cfg_idx[0]] = cfg_wdata;
        else           m_d[cfg_idx[0]] = cfg_wdata;
      end
    end
    #2;
    actv = {rsp_valid, rsp_hit, rsp_win, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault,
            rsp_phys, rsp_probe_stat};
    n_checks++;
    if (actv !== expv) begin
      n_fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", cur_tag, $time, actv, expv);
    end
  end

  task automatic idle(string tag);
    @(negedge clk);
    cur_tag = tag; cfg_we = 0; req_valid = 0;
  endtask

  task automatic wcfg(string tag, bit ins, logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    cur_tag = tag; cfg_we = 1; cfg_instr = ins; cfg_idx = idx; cfg_wdata = d;
    req_valid = 0;
  endtask

  task automatic rq(string tag, logic [31:0] a, bit sup, bit fet, bit st, bit pr);
    @(negedge clk);
    cur_tag = tag; cfg_we = 0; req_valid = 1; req_addr = a;
    req_super = sup; req_fetch = fet; req_store = st; req_probe = pr;
  endtask

  task automatic wrq(string tag, logic [31:0] d, logic [31:0] a);
    @(negedge clk);
    cur_tag = tag; cfg_we = 1; cfg_instr = 0; cfg_idx = 2'd0; cfg_wdata = d;
    req_valid = 1; req_addr = a; req_super = 0; req_fetch = 0;
    req_store = 0; req_probe = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_instr = 0; cfg_idx = 0; cfg_wdata = 0;
    req_valid = 0; req_addr = 0; req_super = 0; req_fetch = 0;
    req_store = 0; req_probe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) idle("R1");
    // R1: nothing enabled after reset
    rq("R1", 32'h1234_5678, 0, 0, 0, 0);
    rq("R1", 32'h0000_0000, 1, 1, 1, 1);
    // R2: disabled window never matches
    wcfg("R11", 0, 2'd0, mk(8'h12, 8'h00, 0, 2'b10, 0));
    rq("R2", 32'h1234_5678, 0, 0, 0, 0);
    wcfg("R11", 0, 2'd0, mk(8'h12, 8'h00, 1, 2'b10, 0));
    rq("R8", 32'h1234_5678, 0, 0, 0, 0);
    // R4: ignore mask on the upper byte
    wcfg("R11", 0, 2'd0, mk(8'h40, 8'h0F, 1, 2'b10, 0));
    rq("R4", 32'h4A00_0010, 0, 0, 0, 0);
    rq("R4", 32'h5000_0010, 0, 0, 0, 0);
    rq("R4", 32'h4FFF_FFFF, 1, 0, 0, 0);
    wcfg("R11", 0, 2'd0, mk(8'h00, 8'hFF, 1, 2'b10, 0));
    rq("R4", 32'hDEAD_BEEF, 0, 0, 0, 0);
    // R3: privilege selector
    wcfg("R11", 0, 2'd0, mk(8'h80, 8'h00, 1, 2'b00, 0));
    rq("R3", 32'h8000_1000, 1, 0, 0, 0);
    rq("R3", 32'h8000_1000, 0, 0, 0, 0);
    wcfg("R11", 0, 2'd0, mk(8'h80, 8'h00, 1, 2'b01, 0));
    rq("R3", 32'h8000_1000, 1, 0, 0, 0);
    rq("R3", 32'h8000_1000, 0, 0, 0, 0);
    wcfg("R11", 0, 2'd0, mk(8'h80, 8'h00, 1, 2'b11, 0));
    rq("R3", 32'h8000_1000, 1, 0, 0, 0);
    rq("R3", 32'h8000_1000, 0, 0, 0, 0);
    // R5 and R10: write protection
    wcfg("R11", 0, 2'd0, mk(8'h80, 8'h00, 1, 2'b10, 1));
    rq("R5", 32'h8000_2000, 0, 0, 0, 0);
    rq("R10", 32'h8000_2000, 0, 0, 1, 0);
    rq("R10", 32'h9000_2000, 0, 0, 1, 0);
    wcfg("R11", 0, 2'd0, mk(8'h80, 8'h00, 1, 2'b10, 0));
    rq("R10", 32'h8000_2000, 1, 0, 1, 0);
    // R6: fetch flag picks the pair
    wcfg("R11", 1, 2'd0, mk(8'hC0, 8'h00, 1, 2'b10, 0));
    rq("R6", 32'hC000_0004, 0, 1, 0, 0);
    rq("R6", 32'hC000_0004, 0, 0, 0, 0);
    rq("R6", 32'h8000_0004, 0, 1, 0, 0);
    rq("R6", 32'h8000_0004, 0, 0, 0, 0);
    // R7: lowest-numbered window wins
    wcfg("R11", 0, 2'd0, mk(8'h20, 8'h00, 1, 2'b10, 1));
    wcfg("R11", 0, 2'd1, mk(8'h20, 8'h03, 1, 2'b10, 0));
    rq("R7", 32'h2000_0000, 0, 0, 0, 0);
    rq("R7", 32'h2300_0000, 0, 0, 1, 0);
    wcfg("R11", 0, 2'd0, mk(8'h20, 8'h00, 0, 2'b10, 1));
    rq("R7", 32'h2000_0000, 0, 0, 1, 0);
    // R9: probe status
    rq("R9", 32'h2100_0000, 0, 0, 0, 1);
    rq("R9", 32'h7700_0000, 0, 0, 0, 1);
    rq("R9", 32'h2100_0000, 0, 0, 0, 0);
    // R11: out-of-range indices ignored, same-cycle request sees old word
    wcfg("R11", 0, 2'd2, mk(8'h66, 8'h00, 1, 2'b10, 0));
    wcfg("R11", 1, 2'd3, mk(8'h66, 8'h00, 1, 2'b10, 0));
    rq("R11", 32'h6600_0000, 0, 0, 0, 0);
    rq("R11", 32'h6600_0000, 0, 1, 0, 0);
    wrq("R11", mk(8'h77, 8'h00, 1, 2'b10, 0), 32'h7700_0000);
    rq("R11", 32'h7700_0000, 0, 0, 0, 0);
    // R12: idle cycles clear the response
    idle("R12");
    idle("R12");
    rq("R12", 32'h7700_0040, 0, 0, 0, 1);
    idle("R12");
    idle("R12");
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule